// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets a bus host read and write a bank of 8-bit registers. It answers only to one fixed 7-bit address. It watches already-synchronised samples of SCL and SDA and pulls SDA low through an open-drain enable. After the address byte, a write transfer loads an internal register pointer. Each following data byte is written to the register at the pointer, and the pointer then advances. A read transfer, normally placed after a pointer write and a repeated START, streams register contents from the pointer. The pointer advances after every byte that the host acknowledges.

On its register side the block gives a one-cycle write strobe with address and data. It also takes a read-data input, which must show the contents of the addressed register combinationally. A transaction watchdog counts clock cycles from START to STOP. If a transfer stays open too long, the watchdog releases SDA and returns the protocol engine to idle. The engine then ignores the bus until a fresh START.

Top module: `regTargetI2c`

## Requirements
- R1: After reset, sdaDriveLow and regWrEn are 0 and regAddr is 0.
- R2: The first byte after a START is taken MSB first as a 7-bit address followed by a direction bit (0 write, 1 read). If the address equals TGT_ADDR (default 0110010, 0x32), the block pulls SDA low for the whole ninth SCL clock as an ACK.
- R3: If the address does not match, SDA stays released during the ninth clock (NACK). No write strobe and no SDA drive occur until the next START or STOP.
- R4: In a write transfer, the byte after the address loads the register pointer and is ACKed. A value of REG_COUNT or more loads 0.
- R5: Each further byte of a write transfer is ACKed. It produces exactly one regWrEn pulse, while SCL is low, with regAddr equal to the pointer and regWrData equal to the byte. The pointer then advances by one.
- R6: In a read transfer, the block sends regRdData for the current pointer MSB first. It changes SDA only after SCL falls and releases SDA during the ninth clock. A host ACK (SDA low in the ninth clock) advances the pointer, and the next byte follows.
- R7: A host NACK on a read byte ends the transmission. SDA stays released until the next START or STOP, and the pointer is not advanced.
- R8: Pointer advance wraps from REG_COUNT-1 to 0 for both reads and writes, so regAddr never reaches REG_COUNT.
- R9: A repeated START restarts address reception and keeps the pointer. A START or a STOP releases SDA on the following cycle.
- R10: If TIMEOUT_CYC cycles pass between a START and the next STOP, SDA is released and the engine goes idle. A repeated START does not restart this count. Bytes clocked afterwards are not ACKed and cause no writes until a new START.
- R11: The block only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL sample |
| sdaIn | input | 1 | Synchronised SDA sample (wired bus value) |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| regWrEn | output | 1 | One-cycle register write strobe |
| regAddr | output | PTR_W | Register pointer, used for writes and reads |
| regWrData | output | 8 | Data for the register write |
| regRdData | input | 8 | Contents of the register at regAddr |

## Verification
The properties assume that SCL and SDA arrive already synchronised. Each SCL low and high phase must last at least a few clock cycles, and the host must move SDA only while SCL is low, except when it forms START and STOP. Under those conditions a fall of SCL is seen while SCL is still low, which is what makes the SDA-drive and write-strobe timing checks valid. The bench keeps within these limits by building every bus phase from a fixed number of clock cycles. It also forms the bus value as the host's level ANDed with the inverse of the block's drive, as a pull-up bus would.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phaseT;

  // strobes from protocol control to the datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into the receive byte
    logic loadPtr;    // take the receive byte as register pointer
    logic writeByte;  // issue a register write of the receive byte
    logic incPtr;     // advance pointer after a host-acked read byte
    logic loadTx;     // load transmit byte from read data
    logic shiftTx;    // move to next transmit bit
  } dpCmdT;

endpackage

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter int REG_COUNT = 24,
  parameter int PTR_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmdT            cmd,
  input  logic             sdaIn,
  input  logic [7:0]       regRdData,
  output logic [7:0]       rxByte,
  output logic             txNextBit,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData
);

  logic [6:0]       txRest;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrAdv;

  assign ptrAdv    = (ptr == PTR_W'(REG_COUNT - 1)) ? '0 : ptr + 1'b1;
  assign txNextBit = txRest[6];
  assign regAddr   = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte    <= '0;
      txRest    <= '0;
      ptr       <= '0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      if (cmd.shiftIn) rxByte <= {rxByte[6:0], sdaIn};
      if (cmd.loadTx) txRest <= regRdData[6:0];
      else if (cmd.shiftTx) txRest <= {txRest[5:0], 1'b0};
      regWrEn <= cmd.writeByte;
      if (cmd.writeByte) regWrData <= rxByte;
      // pointer steps once the write strobe has been presented
      if (cmd.loadPtr) ptr <= (int'(rxByte) < REG_COUNT) ? rxByte[PTR_W-1:0] : '0;
      else if (cmd.incPtr || regWrEn) ptr <= ptrAdv;
    end
  end

endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h32,
  parameter int TIMEOUT_CYC = 250_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txNextBit,
  input  logic       rdMsb,
  output dpCmdT      cmd,
  output logic       sdaLow
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  phaseT        phase, phaseN;
  logic [3:0]   bitCnt, bitN;
  logic         inAck, ackN, lowN, isRead, readN;
  logic         sclPrev, sdaPrev;
  logic [TW-1:0] toCnt;
  logic         sclRise, sclFall, startSeen, stopSeen, expired, busy;

  assign sclRise   = sclIn & ~sclPrev;
  assign sclFall   = ~sclIn & sclPrev;
  assign startSeen = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopSeen  = sclIn & sclPrev & ~sdaPrev & sdaIn;
  assign expired   = (toCnt == TW'(TIMEOUT_CYC - 1));
  assign busy      = (phase == PH_ADDR) || (phase == PH_PTR) ||
                     (phase == PH_WRITE) || (phase == PH_READ);

  always_comb begin
    cmd    = '0;
    phaseN = phase;
    bitN   = bitCnt;
    ackN   = inAck;
    lowN   = sdaLow;
    readN  = isRead;
    if (expired) begin
      phaseN = PH_IDLE; bitN = '0; ackN = 1'b0; lowN = 1'b0;
    end else if (startSeen) begin
      phaseN = PH_ADDR; bitN = '0; ackN = 1'b0; lowN = 1'b0;
    end else if (stopSeen) begin
      phaseN = PH_IDLE; bitN = '0; ackN = 1'b0; lowN = 1'b0;
    end else if (busy && sclRise) begin
      if (!inAck && bitCnt < 4'd8) begin
        bitN = bitCnt + 4'd1;
        cmd.shiftIn = 1'b1;
      end else if (inAck && phase == PH_READ) begin
        if (sdaIn) phaseN = PH_IGNORE;   // host NACK
        else cmd.incPtr = 1'b1;
      end
    end else if (busy && sclFall) begin
      if (!inAck) begin
        if (bitCnt == 4'd8) begin
          ackN = 1'b1;
          unique case (phase)
            PH_ADDR: begin
              if (rxByte[7:1] == TGT_ADDR) begin
                lowN = 1'b1; readN = rxByte[0];
              end else begin
                phaseN = PH_IGNORE; ackN = 1'b0;
              end
            end
            PH_PTR:   begin lowN = 1'b1; cmd.loadPtr = 1'b1; end
            PH_WRITE: begin lowN = 1'b1; cmd.writeByte = 1'b1; end
            default:  lowN = 1'b0;       // read: host owns the ack slot
          endcase
        end else if (phase == PH_READ && bitCnt != 4'd0) begin
          cmd.shiftTx = 1'b1;
          lowN = ~txNextBit;
        end
      end else begin
        ackN = 1'b0;
        bitN = '0;
        unique case (phase)
          PH_ADDR: begin
            if (isRead) begin
              phaseN = PH_READ; cmd.loadTx = 1'b1; lowN = ~rdMsb;
            end else begin
              phaseN = PH_PTR; lowN = 1'b0;
            end
          end
          PH_READ: begin cmd.loadTx = 1'b1; lowN = ~rdMsb; end
          default: begin phaseN = PH_WRITE; lowN = 1'b0; end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      sdaLow  <= 1'b0;
      isRead  <= 1'b0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      toCnt   <= '0;
    end else begin
      phase   <= phaseN;
      bitCnt  <= bitN;
      inAck   <= ackN;
      sdaLow  <= lowN;
      isRead  <= readN;
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (phase == PH_IDLE || stopSeen) toCnt <= '0;
      else toCnt <= toCnt + 1'b1;
    end
  end

endmodule

// File: rtl/regTargetI2c.sv
module regTargetI2c
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h32,
  parameter int REG_COUNT = 24,
  parameter int TIMEOUT_CYC = 250_000_000,
  localparam int PTR_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData
);

  dpCmdT      cmd;
  logic [7:0] rxByte;
  logic       txNextBit;

  i2cTgtCtrl #(.TGT_ADDR(TGT_ADDR), .TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txNextBit(txNextBit), .rdMsb(regRdData[7]),
    .cmd(cmd), .sdaLow(sdaDriveLow)
  );

  i2cTgtData #(.REG_COUNT(REG_COUNT), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaIn(sdaIn),
    .regRdData(regRdData), .rxByte(rxByte), .txNextBit(txNextBit),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData)
  );

endmodule

// File: rtl/i2cTgtChecker.sv
module i2cTgtChecker #(
  parameter int REG_COUNT = 24,
  parameter int TIMEOUT_CYC = 250_000_000,
  parameter int PTR_W = $clog2(REG_COUNT)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaIn,
  input logic             sdaDriveLow,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regAddr
);

  localparam int DW = $clog2(TIMEOUT_CYC + 2);

  logic          sclQ, sdaQ;
  logic [DW-1:0] driveRun;
  logic          busStart, busStop;

  assign busStart = sclIn & sclQ & sdaQ & ~sdaIn;
  assign busStop  = sclIn & sclQ & ~sdaQ & sdaIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; driveRun <= '0;
    end else begin
      sclQ <= sclIn; sdaQ <= sdaIn;
      driveRun <= sdaDriveLow ? driveRun + 1'b1 : '0;
    end
  end

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_wr_scl_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sclIn);

  assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(regAddr) < REG_COUNT);

  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> !sdaDriveLow);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !sdaDriveLow);

  assert_drive_bounded_R10: assert property (@(posedge clk) disable iff (!rstN)
    int'(driveRun) <= TIMEOUT_CYC);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

endmodule

bind regTargetI2c i2cTgtChecker #(.REG_COUNT(REG_COUNT), .TIMEOUT_CYC(TIMEOUT_CYC)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/sim_regTargetI2c.sv
`timescale 1ns/1ps
module sim_regTargetI2c;

  localparam int REG_COUNT = 24;
  localparam int PTR_W = $clog2(REG_COUNT);
  localparam int TIMEOUT = 3000;
  localparam int Q = 4;
  localparam logic [7:0] AW = 8'h64;   // 0x32 with write bit
  localparam logic [7:0] AR = 8'h65;   // 0x32 with read bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, mSda = 1'b1;
  logic sdaBus;
  logic sdaDriveLow, regWrEn;
  logic [PTR_W-1:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [REG_COUNT];
  logic [7:0] expMem [REG_COUNT];
  logic [PTR_W+7:0] expQ [$];
  int total = 0, bad = 0, cyc = 0;
  logic prevDrive = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  assign sdaBus = mSda & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  regTargetI2c #(.TGT_ADDR(7'h32), .REG_COUNT(REG_COUNT), .TIMEOUT_CYC(TIMEOUT)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (regWrEn) mem[regAddr] <= regWrData;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the oldest expected write
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        if (expQ.size() == 0) chk(0, "R5 unexpected write", {regAddr, regWrData}, 0);
        else begin
          logic [PTR_W+7:0] e;
          e = expQ.pop_front();
          chk({regAddr, regWrData} == e, "R5/R8 write addr:data", {regAddr, regWrData}, e);
        end
      end
      if (sdaDriveLow && !prevDrive) chk(!scl, "R11 drive began with SCL low", scl, 0);
      prevDrive <= sdaDriveLow;
    end
  end

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b, output logic seen);
    mSda = b; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    seen = sdaBus; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    mSda = 1'b0; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    mSda = 1'b1; waitQ(Q);
  endtask

  task automatic send8(input logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(d[i], s);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic s;
    send8(d);
    clkBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      d[i] = s;
    end
    clkBit(~hostAck, s);
  endtask

  // write transfer: pointer then data; expected writes go to the scoreboard
  task automatic writeRegs(input logic [7:0] p, input logic [7:0] d [$]);
    logic a;
    int ptr;
    startCond();
    sendByte(AW, a); chk(a, "R2 address ack (write)", a, 1);
    sendByte(p, a);  chk(a, "R4 pointer ack", a, 1);
    ptr = (int'(p) < REG_COUNT) ? int'(p) : 0;
    foreach (d[i]) begin
      expQ.push_back({PTR_W'(ptr), d[i]});
      expMem[ptr] = d[i];
      sendByte(d[i], a); chk(a, "R5 data ack", a, 1);
      ptr = (ptr == REG_COUNT - 1) ? 0 : ptr + 1;
    end
    stopCond();
    waitQ(2);
    chk(!sdaDriveLow, "R9 released after STOP", sdaDriveLow, 0);
  endtask

  // pointer write, repeated START, read n bytes, NACK the last
  task automatic readRegs(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    int ptr;
    startCond();
    sendByte(AW, a); chk(a, "R2 address ack", a, 1);
    sendByte(p, a);  chk(a, "R4 pointer ack", a, 1);
    startCond();
    sendByte(AR, a); chk(a, "R9 address ack after repeated START", a, 1);
    ptr = int'(p);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, d);
      chk(d == expMem[ptr], "R6/R8 read data", d, expMem[ptr]);
      if (i != n - 1) ptr = (ptr == REG_COUNT - 1) ? 0 : ptr + 1;
    end
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic sawLow;
    int t0;
    for (int i = 0; i < REG_COUNT; i++) begin mem[i] = 8'h00; expMem[i] = 8'h00; end
    waitQ(5);
    chk(!sdaDriveLow, "R1 sdaDriveLow in reset", sdaDriveLow, 0);
    rstN = 1'b1;
    waitQ(3);
    chk(!sdaDriveLow, "R1 sdaDriveLow after reset", sdaDriveLow, 0);
    chk(!regWrEn, "R1 regWrEn after reset", regWrEn, 0);
    chk(regAddr == 0, "R1 regAddr after reset", regAddr, 0);

    // plain write and read-back with auto-increment
    writeRegs(8'd5, '{8'hA1, 8'hB2, 8'hC3});
    chk(regAddr == 8, "R5 pointer after three writes", regAddr, 8);
    readRegs(8'd5, 3);

    // after host NACK the block stays off the bus
    sawLow = 1'b0;
    for (int i = 0; i < 9; i++) begin
      clkBit(1'b1, a);
      if (!a) sawLow = 1'b1;
    end
    chk(!sawLow, "R7 SDA released after host NACK", sawLow, 0);
    stopCond();
    chk(regAddr == 7, "R7 pointer not advanced on NACK", regAddr, 7);
    startCond();
    sendByte(AR, a); chk(a, "R2 address ack (read)", a, 1);
    recvByte(1'b0, d);
    chk(d == 8'hC3, "R7 read resumes at un-advanced pointer", d, 8'hC3);
    stopCond();

    // wrap on writes and on reads
    writeRegs(8'd22, '{8'h11, 8'h22, 8'h33});
    readRegs(8'd23, 2);
    stopCond();

    // out-of-range pointer
    writeRegs(8'hF0, '{8'h5A});

    // address mismatch: no ack, no writes, no drive
    startCond();
    sendByte(8'h66, a); chk(!a, "R3 mismatch NACK", a, 0);
    sendByte(8'h00, a); chk(!a, "R3 later byte ignored", a, 0);
    sendByte(8'h77, a); chk(!a, "R3 later byte ignored", a, 0);
    chk(!sdaDriveLow, "R3 SDA released", sdaDriveLow, 0);
    stopCond();

    // watchdog: counter must survive the repeated START
    t0 = cyc;
    startCond();
    sendByte(AW, a); chk(a, "R10 setup address ack", a, 1);
    sendByte(8'd2, a); chk(a, "R10 setup pointer ack", a, 1);
    startCond();
    send8(AW);           // now in the ack slot, SCL held low
    while (cyc < t0 + TIMEOUT - 30) @(negedge clk);
    chk(sdaDriveLow, "R10 still acking before limit", sdaDriveLow, 1);
    while (cyc < t0 + TIMEOUT + 20) @(negedge clk);
    chk(!sdaDriveLow, "R10 released at limit from first START", sdaDriveLow, 0);
    clkBit(1'b1, a);
    sendByte(8'h44, a); chk(!a, "R10 byte after timeout not acked", a, 0);
    stopCond();

    // recovery after timeout
    writeRegs(8'd1, '{8'h99});
    waitQ(4);
    chk(expQ.size() == 0, "R5 all expected writes seen", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule